// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for a control reply (acknowledgement or clear-to-send) that answers a frame just received. Software holds two 16-bit rate bitmaps: a preferred table of rates the network has agreed on, and a backup table of rates every station must support. When the receive path pulses a request and gives the rate of the incoming frame, the block finds the fastest rate in the preferred table that is no faster than the incoming frame. If the preferred table offers nothing suitable, it runs the same search over the backup table. If neither table offers a rate, it answers at 1 Mb/s and flags that case.

The block ranks rates by their true bit rate, not by their bit position. The bitmap keeps the spread-spectrum rates in its low nibble and the OFDM rates in its high byte, so 11 Mb/s sits below 6 Mb/s in the bitmap but above 9 Mb/s in speed. The result is registered: a rate code, an OFDM flag and a fallback flag. They appear one cycle after the request and hold until the next request.

Top module: `resp_rate_sel`

## Requirements
- R1: While reset is asserted, and until the first request after it, rsp_valid_o, rsp_rate_o, rsp_ofdm_o and rsp_fallback_o are all zero.
- R2: rsp_valid_o is high in exactly the cycle after each cycle in which req_i is high. The rate, OFDM and fallback outputs change only in that cycle and keep their values while no request arrives, whatever the inputs do.
- R3: Rate codes are ordered by speed: 0=1, 1=2, 2=5.5, 3=6, 4=9, 5=11, 6=12, 7=18, 8=24, 9=36, 10=48, 11=54 Mb/s. Bitmap bits 0, 1, 2, 3 hold 1, 2, 5.5 and 11 Mb/s. Bits 8 to 15 hold 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s. The same codes are used for rx_rate_i and rsp_rate_o.
- R4: If the preferred table (basic_map_i) has at least one set rate no faster than the incoming rate, the output is the fastest such rate.
- R5: Only when R4 finds nothing is the backup table (mand_map_i) searched, with the same no-faster rule and the same choice of the fastest candidate.
- R6: If neither table qualifies, rsp_rate_o is 0 (1 Mb/s) and rsp_fallback_o is 1. Otherwise rsp_fallback_o is 0.
- R7: Bits 4 to 7 of either bitmap have no effect on any output.
- R8: rsp_ofdm_o is 1 for codes 3, 4 and 6 to 11, and 0 for codes 0, 1, 2 and 5.
- R9: An incoming rate code of 12 to 15 is treated as code 11 (54 Mb/s).
- R10: The ranking follows speed across the two bitmap halves. With 9 and 11 Mb/s both allowed and an 11 Mb/s frame, the reply is 11 Mb/s. With 11 and 12 Mb/s allowed and a 12 Mb/s frame, the reply is 12 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | One-cycle strobe asking for a reply rate |
| rx_rate_i | input | 4 | Speed-ordered code of the received frame's rate |
| basic_map_i | input | 16 | Preferred rate bitmap |
| mand_map_i | input | 16 | Backup rate bitmap |
| rsp_valid_o | output | 1 | High for one cycle when a new result is presented |
| rsp_rate_o | output | 4 | Chosen rate, speed-ordered code |
| rsp_ofdm_o | output | 1 | Chosen rate is an OFDM rate |
| rsp_fallback_o | output | 1 | Neither table held a usable rate |

## Verification
The sweep goes after the ranking across the two bitmap halves. A design that ranked by bit position would answer 9 Mb/s where 11 Mb/s is due, or pick 11 Mb/s over a slower OFDM rate that it wrongly believes faster. The sweep also covers the exact-equal boundary, where a strict comparison would drop the incoming rate itself, and the table order, where a design that merged the tables would pick a faster backup rate over a slower preferred one. Bitmaps with only bits 4 to 7 set expose a design that decodes those bits, and incoming codes 12 to 15 expose one that masks out every rate. Held-output checks with changing inputs catch a register that loads without a request.

// File: rtl/resp_rate_pkg.sv
package resp_rate_pkg;

  localparam int RATE_COUNT = 12;
  localparam int MAP_WIDTH  = 16;
  localparam int CODE_WIDTH = 4;

  // Bitmap position of each speed-ordered rate code.
  function automatic int unsigned code_bit(input int unsigned code);
    case (code)
      0, 1, 2: code_bit = code;      // 1, 2, 5.5 Mb/s
      3:       code_bit = 8;         // 6 Mb/s
      4:       code_bit = 9;         // 9 Mb/s
      5:       code_bit = 3;         // 11 Mb/s
      default: code_bit = code + 4;  // 12 .. 54 Mb/s
    endcase
  endfunction

  function automatic logic code_is_ofdm(input int unsigned code);
    code_is_ofdm = (code == 3) || (code == 4) || (code >= 6);
  endfunction

endpackage

// File: rtl/resp_rst_sync.sv
module resp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rate_rank_sort.sv
// Reorders a bitmap into a speed-ordered candidate vector; unused bits drop out.
module rate_rank_sort
  import resp_rate_pkg::*;
#(
  parameter int MAP_W     = MAP_WIDTH,
  parameter int NUM_RATES = RATE_COUNT
) (
  input  logic [MAP_W-1:0]     map_i,
  output logic [NUM_RATES-1:0] rank_o
);
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rank
    localparam int unsigned BIT_POS = code_bit(g);
    assign rank_o[g] = map_i[BIT_POS];
  end
endmodule

// File: rtl/rate_ceiling_mask.sv
// Thermometer mask of all rate codes no faster than the incoming code.
module rate_ceiling_mask #(
  parameter int CODE_W    = 4,
  parameter int NUM_RATES = 12
) (
  input  logic [CODE_W-1:0]    code_i,
  output logic [CODE_W-1:0]    eff_o,
  output logic [NUM_RATES-1:0] mask_o
);
  localparam int TOP = NUM_RATES - 1;

  always_comb begin
    if (code_i > CODE_W'(TOP)) eff_o = CODE_W'(TOP);
    else                       eff_o = code_i;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_mask
    assign mask_o[g] = (CODE_W'(g) <= eff_o);
  end
endmodule

// File: rtl/rate_top_pick.sv
// Finds the highest set candidate; the index is the rate code.
module rate_top_pick #(
  parameter int CODE_W    = 4,
  parameter int NUM_RATES = 12
) (
  input  logic [NUM_RATES-1:0] cand_i,
  output logic                 found_o,
  output logic [CODE_W-1:0]    idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/resp_rate_sel.sv
module resp_rate_sel
  import resp_rate_pkg::*;
#(
  parameter int MAP_W     = MAP_WIDTH,
  parameter int CODE_W    = CODE_WIDTH,
  parameter int NUM_RATES = RATE_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CODE_W-1:0] rx_rate_i,
  input  logic [MAP_W-1:0]  basic_map_i,
  input  logic [MAP_W-1:0]  mand_map_i,
  output logic              rsp_valid_o,
  output logic [CODE_W-1:0] rsp_rate_o,
  output logic              rsp_ofdm_o,
  output logic              rsp_fallback_o
);
  localparam logic [CODE_W-1:0] LOWEST_CODE = '0;

  logic                 rst_sync_n;
  logic [NUM_RATES-1:0] basic_rank, mand_rank, ceil_mask;
  logic [NUM_RATES-1:0] basic_cand, mand_cand;
  logic [CODE_W-1:0]    ceil_code, basic_idx, mand_idx, sel_code;
  logic                 basic_found, mand_found, sel_fallback;

  logic              valid_q, valid_d;
  logic [CODE_W-1:0] rate_q,  rate_d;
  logic              ofdm_q,  ofdm_d;
  logic              fb_q,    fb_d;

  resp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rate_rank_sort #(.MAP_W(MAP_W), .NUM_RATES(NUM_RATES)) u_basic_sort (
    .map_i  (basic_map_i),
    .rank_o (basic_rank)
  );

  rate_rank_sort #(.MAP_W(MAP_W), .NUM_RATES(NUM_RATES)) u_mand_sort (
    .map_i  (mand_map_i),
    .rank_o (mand_rank)
  );

  rate_ceiling_mask #(.CODE_W(CODE_W), .NUM_RATES(NUM_RATES)) u_ceiling (
    .code_i (rx_rate_i),
    .eff_o  (ceil_code),
    .mask_o (ceil_mask)
  );

  assign basic_cand = basic_rank & ceil_mask;
  assign mand_cand  = mand_rank  & ceil_mask;

  rate_top_pick #(.CODE_W(CODE_W), .NUM_RATES(NUM_RATES)) u_basic_pick (
    .cand_i  (basic_cand),
    .found_o (basic_found),
    .idx_o   (basic_idx)
  );

  rate_top_pick #(.CODE_W(CODE_W), .NUM_RATES(NUM_RATES)) u_mand_pick (
    .cand_i  (mand_cand),
    .found_o (mand_found),
    .idx_o   (mand_idx)
  );

  // Preferred table first, backup second, lowest rate last.
  always_comb begin
    sel_fallback = 1'b0;
    if (basic_found)     sel_code = basic_idx;
    else if (mand_found) sel_code = mand_idx;
    else begin
      sel_code     = LOWEST_CODE;
      sel_fallback = 1'b1;
    end
  end

  // Next state: results load only on a request.
  always_comb begin
    valid_d = req_i;
    rate_d  = rate_q;
    ofdm_d  = ofdm_q;
    fb_d    = fb_q;
    if (req_i) begin
      rate_d = sel_code;
      ofdm_d = code_is_ofdm(int'(sel_code));
      fb_d   = sel_fallback;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      rate_q  <= '0;
      ofdm_q  <= 1'b0;
      fb_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      rate_q  <= rate_d;
      ofdm_q  <= ofdm_d;
      fb_q    <= fb_d;
    end
  end

  assign rsp_valid_o    = valid_q;
  assign rsp_rate_o     = rate_q;
  assign rsp_ofdm_o     = ofdm_q;
  assign rsp_fallback_o = fb_q;

  AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> rsp_valid_o); // R2
  AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !rsp_valid_o); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> ($stable(rsp_rate_o) && $stable(rsp_fallback_o) && $stable(rsp_ofdm_o))); // R2
  AST_NOT_ABOVE_RX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && !rsp_fallback_o) |-> (rsp_rate_o <= $past(ceil_code))); // R4
  AST_PREFERRED_USED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && $past(basic_found))
      |-> ((($past(basic_map_i) >> code_bit(int'(rsp_rate_o))) & MAP_W'(1)) != '0)); // R4
  AST_BACKUP_USED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && !$past(basic_found) && !rsp_fallback_o)
      |-> ((($past(mand_map_i) >> code_bit(int'(rsp_rate_o))) & MAP_W'(1)) != '0)); // R5
  AST_FALLBACK_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_fallback_o |-> (rsp_rate_o == LOWEST_CODE)); // R6
  AST_FALLBACK_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && rsp_fallback_o) |-> ($past(basic_cand) == '0 && $past(mand_cand) == '0)); // R6
endmodule

// File: tb/resp_rate_sel_bench.sv
module resp_rate_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  rx_rate_i = '0;
  logic [15:0] basic_map_i = '0;
  logic [15:0] mand_map_i = '0;
  logic        rsp_valid_o, rsp_ofdm_o, rsp_fallback_o;
  logic [3:0]  rsp_rate_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  resp_rate_sel u_resp_rate_sel (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rx_rate_i(rx_rate_i),
    .basic_map_i(basic_map_i), .mand_map_i(mand_map_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rate_o(rsp_rate_o),
    .rsp_ofdm_o(rsp_ofdm_o), .rsp_fallback_o(rsp_fallback_o)
  );

  // Speed in kb/s of each bitmap position (0 = unused), per R3.
  function automatic int kbps_of_bit(input int b);
    case (b)
      0: return 1000;   1: return 2000;   2: return 5500;   3: return 11000;
      8: return 6000;   9: return 9000;  10: return 12000; 11: return 18000;
      12: return 24000; 13: return 36000; 14: return 48000; 15: return 54000;
      default: return 0;
    endcase
  endfunction

  // Speed of a speed-ordered code; codes above 11 clamp to 54 Mb/s (R9).
  function automatic int kbps_of_code(input int c);
    case (c)
      0: return 1000;   1: return 2000;  2: return 5500;  3: return 6000;
      4: return 9000;   5: return 11000; 6: return 12000; 7: return 18000;
      8: return 24000;  9: return 36000; 10: return 48000;
      default: return 54000;
    endcase
  endfunction

  function automatic int best_kbps(input logic [15:0] map, input int ceil_k);
    int best = 0;
    for (int b = 0; b < 16; b++)
      if (map[b] && kbps_of_bit(b) > 0 && kbps_of_bit(b) <= ceil_k && kbps_of_bit(b) > best)
        best = kbps_of_bit(b);
    return best;
  endfunction

  function automatic int code_of_kbps(input int k);
    for (int c = 0; c < 12; c++) if (kbps_of_code(c) == k) return c;
    return 0;
  endfunction

  function automatic logic ofdm_of_kbps(input int k);
    for (int b = 8; b < 16; b++) if (kbps_of_bit(b) == k) return 1'b1;
    return 1'b0;
  endfunction

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  // One request; compares the registered result against the arithmetic model.
  task automatic do_req(input int rx, input logic [15:0] bmap, input logic [15:0] mmap,
                        input string tag);
    int ck, bk, mk, exp_code, exp_fb;
    logic exp_ofdm;
    string req;
    ck = kbps_of_code(rx);
    bk = best_kbps(bmap, ck);
    mk = best_kbps(mmap, ck);
    if (bk > 0)      begin exp_code = code_of_kbps(bk); exp_fb = 0; exp_ofdm = ofdm_of_kbps(bk); req = "R4"; end
    else if (mk > 0) begin exp_code = code_of_kbps(mk); exp_fb = 0; exp_ofdm = ofdm_of_kbps(mk); req = "R5"; end
    else             begin exp_code = 0; exp_fb = 1; exp_ofdm = 1'b0; req = "R6"; end
    if (tag != "") req = tag;
    req_i = 1'b1; rx_rate_i = 4'(rx); basic_map_i = bmap; mand_map_i = mmap;
    @(posedge clk); @(negedge clk);
    req_i = 1'b0;
    checks++;
    if (!rsp_valid_o) fail_line("R2", "valid after request", int'(rsp_valid_o), 1);
    checks++;
    if (int'(rsp_rate_o) != exp_code || int'(rsp_fallback_o) != exp_fb) begin
      errors++;
      $display("FAIL %s rx=%0d basic=%h mand=%h: actual rate=%0d fb=%0d expected rate=%0d fb=%0d",
               req, rx, bmap, mmap, rsp_rate_o, rsp_fallback_o, exp_code, exp_fb);
    end
    check_int("R8", "ofdm flag", int'(rsp_ofdm_o), int'(exp_ofdm));
  endtask

  // R2: outputs hold while inputs change without a request.
  task automatic hold_check;
    int r, f, o;
    r = int'(rsp_rate_o); f = int'(rsp_fallback_o); o = int'(rsp_ofdm_o);
    basic_map_i = ~basic_map_i; mand_map_i = ~mand_map_i; rx_rate_i = ~rx_rate_i;
    repeat (2) @(negedge clk);
    check_int("R2", "valid without request", int'(rsp_valid_o), 0);
    check_int("R2", "held rate", int'(rsp_rate_o), r);
    check_int("R2", "held fallback", int'(rsp_fallback_o), f);
    check_int("R2", "held ofdm", int'(rsp_ofdm_o), o);
  endtask

  task automatic check_reset_state(input string why);
    check_int("R1", {why, " valid"}, int'(rsp_valid_o), 0);
    check_int("R1", {why, " rate"}, int'(rsp_rate_o), 0);
    check_int("R1", {why, " ofdm"}, int'(rsp_ofdm_o), 0);
    check_int("R1", {why, " fallback"}, int'(rsp_fallback_o), 0);
  endtask

  initial begin : main
    logic [15:0] pats [10];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h000F; pats[3] = 16'hFF00;
    pats[4] = 16'h00F0; pats[5] = 16'h0208; pats[6] = 16'h0408; pats[7] = 16'h0103;
    pats[8] = 16'hA005; pats[9] = 16'h5F0A;

    basic_map_i = 16'hFFFF; mand_map_i = 16'hFFFF; rx_rate_i = 4'd11;
    repeat (3) @(negedge clk);
    check_reset_state("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("after release");

    // R10: speed ordering across the two bitmap halves.
    do_req(5, 16'h0208, 16'h0000, "R10");
    check_int("R10", "11M over 9M", int'(rsp_rate_o), 5);
    do_req(6, 16'h0408, 16'h0000, "R10");
    check_int("R10", "12M over 11M", int'(rsp_rate_o), 6);
    do_req(4, 16'h0408, 16'h0000, "R10");
    check_int("R10", "9M frame with 11M/12M table", int'(rsp_fallback_o), 1);

    // R7: only reserved bits set.
    do_req(11, 16'h00F0, 16'h00F0, "R7");
    check_int("R7", "reserved bits give fallback", int'(rsp_fallback_o), 1);
    do_req(11, 16'h00F4, 16'h0000, "R7");
    check_int("R7", "reserved bits beside 5.5M", int'(rsp_rate_o), 2);

    // R9: clamped incoming codes.
    for (int rx = 12; rx < 16; rx++) begin
      do_req(rx, 16'h8001, 16'h0000, "R9");
      hold_check();
    end

    // R5 vs R4 ordering: slower preferred beats faster backup.
    do_req(11, 16'h0001, 16'hFF00, "R4");
    check_int("R4", "preferred 1M before backup", int'(rsp_rate_o), 0);
    do_req(3, 16'h8000, 16'h0100, "R5");
    check_int("R5", "backup exact equal 6M", int'(rsp_rate_o), 3);

    // R3: exact-equal boundary for every code, each rate alone.
    for (int c = 0; c < 12; c++) begin
      do_req(c, 16'h0000, 16'h0000, "R6");
      for (int b = 0; b < 16; b++) begin
        if (kbps_of_bit(b) == kbps_of_code(c)) begin
          do_req(c, 16'(1) << b, 16'h0000, "R3");
          check_int("R3", "single rate equal to rx", int'(rsp_rate_o), c);
        end
      end
    end

    // Sweep: all incoming codes against pattern pairs.
    for (int rx = 0; rx < 16; rx++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++) begin
          do_req(rx, pats[i], pats[j], "");
          if ((i + j + rx) % 37 == 0) hold_check();
        end

    // Pseudo-random maps.
    for (int n = 0; n < 800; n++) begin
      logic [15:0] bm, mm;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      bm = lfsr[15:0] & lfsr[31:16];
      mm = lfsr[31:16];
      do_req(int'(lfsr[7:4]), bm, mm, "");
    end

    // R1: asynchronous reset mid-run.
    do_req(11, 16'hFFFF, 16'h0000, "R4");
    #1 rst_n = 1'b0;
    #1 check_reset_state("async reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("re-release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule